// File: doc/BRIEF.md
# Link Speed Bring-Up Sequencer

This block runs the start-up of a serial link from the root side of the link. After a start command it limits the link controller to the first generation, enables training and waits for link-up. If the target sampled at start allows the second generation, it raises the speed limit, requests a directed speed change, waits for the change to finish, and waits for link-up again. On success it records the negotiated generation that the controller reports.

When any wait runs out, the block recovers the PHY receiver. It reads one PHY register through a request port, sets two override bits (receiver data enable and receiver PLL enable), holds them for a programmable time, reads the register again, clears the same two bits and writes the register back. The link controller is seen through plain register-style words: a speed-limit field, a one-cycle speed-change set pulse, a training enable, and three status words read back. Each PHY request is a valid/ready transfer. The block holds `phy_req_valid_o` and all request fields steady until `phy_req_ready_i` is seen high at a clock edge. A read completes when `phy_rsp_valid_i` returns its data, and that response cannot be back-pressured. A write completes on acceptance.

Top module: `link_speed_seq`

## Requirements
- R1: `start_i` is acted on only while `busy_o` is low. It clears `done_o`, `error_o` and `cur_gen_o`, samples `cfg_gen2_en_i`, and raises `busy_o` at the next edge. A start pulse while busy has no effect on the speed limit, training enable or outcome.
- R2: `spd_limit_o` is driven to 1 before `train_en_o` first rises in a run.
- R3: The link counts as up when bit 4 of `lnk_dbg_i` is 1 and bit 29 (training in progress) is 0. This is sampled once every POLL_CYCLES cycles. A link-up first seen on poll number LINK_POLLS still succeeds; if it is not seen by that poll, the run fails.
- R4: With the second generation selected, after the first link-up `spd_limit_o` becomes 2 and `dsc_set_o` pulses high for exactly one cycle in the same cycle.
- R5: After the speed-change request, the block polls bit 17 of `lnk_ctl_i` until it reads 0. It polls at most SPD_POLLS times (200 by default), and if the bit is still 1 at the last poll the run fails.
- R6: With SKIP_DSC_WAIT set, bit 17 of `lnk_ctl_i` is ignored, and only the second link-up wait follows the speed-change request.
- R7: With the first generation selected, no speed-change request is issued, `spd_limit_o` stays 1, and the run completes after the first link-up.
- R8: On success, `cur_gen_o` takes bits [19:16] of `lnk_stat_i` and `done_o` is set.
- R9: On failure, the PHY requests are, in order: a read of address 0x1005; a write of the value read OR 0x0028; a gap of at least RECOV_CYCLES cycles; a read of 0x1005; and a write of the value read AND NOT 0x0028.
- R10: `error_o` rises on the failing poll while `busy_o` stays high through the recovery. `error_o` then remains set until the next accepted start, and `done_o` and `error_o` are never high together.
- R11: While `phy_req_valid_o` is high and `phy_req_ready_i` is low, valid, write flag, address and write data stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch a bring-up run from idle |
| cfg_gen2_en_i | input | 1 | Target generation 2 when high, generation 1 when low |
| spd_limit_o | output | 4 | Maximum link speed field to the controller |
| dsc_set_o | output | 1 | One-cycle pulse setting the directed speed change bit |
| train_en_o | output | 1 | Link training enable |
| lnk_dbg_i | input | 32 | Debug status word: bit 4 link up, bit 29 training |
| lnk_ctl_i | input | 32 | Width/speed control readback: bit 17 speed change pending |
| lnk_stat_i | input | 32 | Link control/status word: bits [19:16] current speed |
| phy_req_valid_o | output | 1 | PHY access request valid |
| phy_req_ready_i | input | 1 | PHY access master accepts the request |
| phy_req_write_o | output | 1 | 1 write, 0 read |
| phy_req_addr_o | output | 16 | PHY register address |
| phy_req_wdata_o | output | 16 | PHY write data |
| phy_rsp_valid_i | input | 1 | Read data valid |
| phy_rsp_rdata_i | input | 16 | Read data |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Sticky: last run succeeded |
| error_o | output | 1 | Sticky: last run failed |
| cur_gen_o | output | 4 | Generation reported on success |

## Verification
The critical coincidence is a link-up that first appears on the very poll whose count exhausts the timeout. Success and expiry are decided in the same cycle, and success must win. The bench raises link-up a known number of cycles after the start edge, chosen so that the last permitted poll sees it. It then repeats the run with link-up two cycles later, past that poll. The first run must end with done and no error; the second must end with error and a complete recovery sequence. The PHY request stream runs under periodic back-pressure, and a behavioural model of the PHY register compares every accepted transfer as it happens.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  localparam int DBG_LINK_UP_BIT  = 4;
  localparam int DBG_TRAINING_BIT = 29;
  localparam int CTL_DSC_BIT      = 17;
  localparam int STAT_SPEED_LSB   = 16;
  localparam int SPEED_W          = 4;

  typedef enum logic [3:0] {
    S_IDLE,
    S_LIMIT1,
    S_TRAIN,
    S_WAIT_UP1,
    S_RAISE,
    S_WAIT_DSC,
    S_WAIT_UP2,
    S_REPORT,
    S_RECOVER
  } seq_state_e;

  typedef enum logic [3:0] {
    R_IDLE,
    R_RD1,
    R_RSP1,
    R_WR1,
    R_HOLD,
    R_RD2,
    R_RSP2,
    R_WR2,
    R_FIN
  } rec_state_e;

endpackage

// File: rtl/lsq_poll_timer.sv
module lsq_poll_timer #(
  parameter int INTERVAL = 250,
  parameter int CNT_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             tick_o,
  output logic             last_o
);

  logic [CNT_W-1:0] count_q;

  generate
    if (INTERVAL <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_phase
      localparam int PH_W = $clog2(INTERVAL);
      logic [PH_W-1:0] phase_q;

      always_ff @(posedge clk) begin
        if (!rst_n || clear_i || tick_o) phase_q <= '0;
        else                             phase_q <= phase_q + 1'b1;
      end

      assign tick_o = (phase_q == PH_W'(INTERVAL - 1));

      p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) count_q <= '0;
    else if (tick_o)       count_q <= count_q + 1'b1;
  end

  assign last_o = tick_o && (count_q == limit_i - 1'b1);

endmodule

// File: rtl/lsq_rx_recover.sv
module lsq_rx_recover
  import lsq_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter int              DATA_W      = 16,
  parameter logic [15:0]     REG_ADDR    = 16'h1005,
  parameter logic [15:0]     SET_MASK    = 16'h0028,
  parameter int              HOLD_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  output logic              fin_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_write_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_rdata_i
);

  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(SET_MASK);

  rec_state_e        st_q, st_d;
  logic [DATA_W-1:0] shadow_q;
  logic [HOLD_W-1:0] hold_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      R_IDLE: if (go_i)          st_d = R_RD1;
      R_RD1:  if (req_ready_i)   st_d = R_RSP1;
      R_RSP1: if (rsp_valid_i)   st_d = R_WR1;
      R_WR1:  if (req_ready_i)   st_d = R_HOLD;
      R_HOLD: if (hold_q == HOLD_W'(HOLD_CYCLES - 1)) st_d = R_RD2;
      R_RD2:  if (req_ready_i)   st_d = R_RSP2;
      R_RSP2: if (rsp_valid_i)   st_d = R_WR2;
      R_WR2:  if (req_ready_i)   st_d = R_FIN;
      R_FIN:                     st_d = R_IDLE;
      default:                   st_d = R_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= R_IDLE;
      shadow_q <= '0;
      hold_q   <= '0;
    end else begin
      st_q <= st_d;
      if ((st_q == R_RSP1 || st_q == R_RSP2) && rsp_valid_i) shadow_q <= rsp_rdata_i;
      if (st_q == R_HOLD) hold_q <= hold_q + 1'b1;
      else                hold_q <= '0;
    end
  end

  assign req_valid_o = (st_q == R_RD1) || (st_q == R_WR1) ||
                       (st_q == R_RD2) || (st_q == R_WR2);
  assign req_write_o = (st_q == R_WR1) || (st_q == R_WR2);
  assign req_addr_o  = ADDR_W'(REG_ADDR);
  assign req_wdata_o = (st_q == R_WR1) ? (shadow_q | MASK) :
                       (st_q == R_WR2) ? (shadow_q & ~MASK) : '0;
  assign fin_o       = (st_q == R_FIN);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_write_o) && $stable(req_addr_o) && $stable(req_wdata_o)));

  p_go_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> (st_q == R_IDLE));

endmodule

// File: rtl/link_speed_seq.sv
module link_speed_seq
  import lsq_pkg::*;
#(
  parameter int POLL_CYCLES   = 250,
  parameter int LINK_POLLS    = 1000,
  parameter int SPD_POLLS     = 200,
  parameter int RECOV_CYCLES  = 500000,
  parameter bit SKIP_DSC_WAIT = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        cfg_gen2_en_i,
  output logic [3:0]  spd_limit_o,
  output logic        dsc_set_o,
  output logic        train_en_o,
  input  logic [31:0] lnk_dbg_i,
  input  logic [31:0] lnk_ctl_i,
  input  logic [31:0] lnk_stat_i,
  output logic        phy_req_valid_o,
  input  logic        phy_req_ready_i,
  output logic        phy_req_write_o,
  output logic [15:0] phy_req_addr_o,
  output logic [15:0] phy_req_wdata_o,
  input  logic        phy_rsp_valid_i,
  input  logic [15:0] phy_rsp_rdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        error_o,
  output logic [3:0]  cur_gen_o
);

  localparam int MAX_POLLS = (LINK_POLLS > SPD_POLLS) ? LINK_POLLS : SPD_POLLS;
  localparam int CNT_W     = $clog2(MAX_POLLS + 1);

  seq_state_e       state_q, state_d;
  logic             gen2_q;
  logic             link_ok, dsc_pending;
  logic             waiting, tmr_clear, tick, last, fail, rec_fin;
  logic [CNT_W-1:0] tmr_limit;

  assign link_ok     = lnk_dbg_i[DBG_LINK_UP_BIT] & ~lnk_dbg_i[DBG_TRAINING_BIT];
  assign dsc_pending = lnk_ctl_i[CTL_DSC_BIT];

  assign waiting   = (state_q == S_WAIT_UP1) || (state_q == S_WAIT_DSC) ||
                     (state_q == S_WAIT_UP2);
  assign tmr_clear = !waiting || (state_d != state_q);
  assign tmr_limit = (state_q == S_WAIT_DSC) ? CNT_W'(SPD_POLLS) : CNT_W'(LINK_POLLS);

  lsq_poll_timer #(
    .INTERVAL (POLL_CYCLES),
    .CNT_W    (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (tmr_clear),
    .limit_i (tmr_limit),
    .tick_o  (tick),
    .last_o  (last)
  );

  always_comb begin
    state_d = state_q;
    fail    = 1'b0;
    unique case (state_q)
      S_IDLE:   if (start_i) state_d = S_LIMIT1;
      S_LIMIT1: state_d = S_TRAIN;
      S_TRAIN:  state_d = S_WAIT_UP1;
      S_WAIT_UP1: begin
        if (tick && link_ok)  state_d = gen2_q ? S_RAISE : S_REPORT;
        else if (last)        begin state_d = S_RECOVER; fail = 1'b1; end
      end
      S_RAISE:  state_d = SKIP_DSC_WAIT ? S_WAIT_UP2 : S_WAIT_DSC;
      S_WAIT_DSC: begin
        if (tick && !dsc_pending) state_d = S_WAIT_UP2;
        else if (last)            begin state_d = S_RECOVER; fail = 1'b1; end
      end
      S_WAIT_UP2: begin
        if (tick && link_ok)  state_d = S_REPORT;
        else if (last)        begin state_d = S_RECOVER; fail = 1'b1; end
      end
      S_REPORT:  state_d = S_IDLE;
      S_RECOVER: if (rec_fin) state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      gen2_q      <= 1'b0;
      spd_limit_o <= '0;
      dsc_set_o   <= 1'b0;
      train_en_o  <= 1'b0;
      done_o      <= 1'b0;
      error_o     <= 1'b0;
      cur_gen_o   <= '0;
    end else begin
      state_q   <= state_d;
      dsc_set_o <= (state_q == S_RAISE);
      if (state_q == S_IDLE && start_i) begin
        gen2_q     <= cfg_gen2_en_i;
        done_o     <= 1'b0;
        error_o    <= 1'b0;
        train_en_o <= 1'b0;
        cur_gen_o  <= '0;
      end
      if (state_q == S_LIMIT1) spd_limit_o <= 4'd1;
      if (state_q == S_TRAIN)  train_en_o  <= 1'b1;
      if (state_q == S_RAISE)  spd_limit_o <= 4'd2;
      if (state_q == S_REPORT) begin
        cur_gen_o <= lnk_stat_i[STAT_SPEED_LSB +: SPEED_W];
        done_o    <= 1'b1;
      end
      if (fail) error_o <= 1'b1;
    end
  end

  assign busy_o = (state_q != S_IDLE);

  lsq_rx_recover #(
    .ADDR_W      (16),
    .DATA_W      (16),
    .REG_ADDR    (16'h1005),
    .SET_MASK    (16'h0028),
    .HOLD_CYCLES (RECOV_CYCLES)
  ) u_recover (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (fail),
    .fin_o       (rec_fin),
    .req_valid_o (phy_req_valid_o),
    .req_ready_i (phy_req_ready_i),
    .req_write_o (phy_req_write_o),
    .req_addr_o  (phy_req_addr_o),
    .req_wdata_o (phy_req_wdata_o),
    .rsp_valid_i (phy_rsp_valid_i),
    .rsp_rdata_i (phy_rsp_rdata_i)
  );

  p_gen1_at_train_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_en_o) |-> (spd_limit_o == 4'd1));

  p_dsc_with_gen2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_set_o |-> (spd_limit_o == 4'd2 && train_en_o && busy_o));

  p_dsc_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_set_o |=> !dsc_set_o);

  p_done_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && error_o));

  p_busy_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o || error_o));

  p_no_phy_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !phy_req_valid_o);

endmodule

// File: tb/link_speed_seq_bench.sv
module link_speed_seq_bench;

  localparam int PC = 4;
  localparam int LP = 8;
  localparam int SP = 200;
  localparam int RC = 40;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start, start_s, gen2;
  logic [31:0] dbg, ctl, stat;
  logic [3:0]  spd_limit, spd_limit_s, cur_gen, cur_gen_s;
  logic        dsc_set, dsc_set_s, train_en, train_en_s;
  logic        req_v, req_w, p_ready, p_rsp_v;
  logic [15:0] req_a, req_d, p_rsp_d;
  logic        busy, done, error, busy_s, done_s, error_s;
  logic        s_req_v, s_req_w;
  logic [15:0] s_req_a, s_req_d;

  link_speed_seq #(.POLL_CYCLES(PC), .LINK_POLLS(LP), .SPD_POLLS(SP),
                   .RECOV_CYCLES(RC), .SKIP_DSC_WAIT(1'b0)) u_link_speed_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_gen2_en_i(gen2),
    .spd_limit_o(spd_limit), .dsc_set_o(dsc_set), .train_en_o(train_en),
    .lnk_dbg_i(dbg), .lnk_ctl_i(ctl), .lnk_stat_i(stat),
    .phy_req_valid_o(req_v), .phy_req_ready_i(p_ready), .phy_req_write_o(req_w),
    .phy_req_addr_o(req_a), .phy_req_wdata_o(req_d),
    .phy_rsp_valid_i(p_rsp_v), .phy_rsp_rdata_i(p_rsp_d),
    .busy_o(busy), .done_o(done), .error_o(error), .cur_gen_o(cur_gen));

  link_speed_seq #(.POLL_CYCLES(PC), .LINK_POLLS(LP), .SPD_POLLS(SP),
                   .RECOV_CYCLES(RC), .SKIP_DSC_WAIT(1'b1)) u_skip (
    .clk(clk), .rst_n(rst_n), .start_i(start_s), .cfg_gen2_en_i(gen2),
    .spd_limit_o(spd_limit_s), .dsc_set_o(dsc_set_s), .train_en_o(train_en_s),
    .lnk_dbg_i(dbg), .lnk_ctl_i(ctl), .lnk_stat_i(stat),
    .phy_req_valid_o(s_req_v), .phy_req_ready_i(1'b1), .phy_req_write_o(s_req_w),
    .phy_req_addr_o(s_req_a), .phy_req_wdata_o(s_req_d),
    .phy_rsp_valid_i(1'b0), .phy_rsp_rdata_i(16'h0000),
    .busy_o(busy_s), .done_o(done_s), .error_o(error_s), .cur_gen_o(cur_gen_s));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit fin = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural PHY register model with back-pressure, compared every clock.
  logic [15:0] phy_reg = 16'h1234;
  int          txn = 0, bp = 0, rsp_wait = -1, t_wr1 = 0, dsc_cnt = 0;
  logic        prev_v = 1'b0, prev_rdy = 1'b0, prev_w = 1'b0, prev_train = 1'b0;
  logic [15:0] prev_a = '0, prev_d = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_v && !prev_rdy)
        chk(req_v && req_a == prev_a && req_d == prev_d && req_w == prev_w,
            "R11 request held", {15'd0, req_v, req_d}, {15'd1, prev_d});
      if (train_en && !prev_train)
        chk(spd_limit == 4'd1, "R2 gen1 limit at training start", spd_limit, 1);
      if (dsc_set) dsc_cnt++;
    end
    p_rsp_v = 1'b0;
    if (rsp_wait == 0) begin
      p_rsp_v  = 1'b1;
      p_rsp_d  = phy_reg;
      rsp_wait = -1;
    end else if (rsp_wait > 0) rsp_wait--;
    bp++;
    p_ready = (bp % 3) != 0;
    if (rst_n && req_v && p_ready) begin
      case (txn % 4)
        0, 2: begin
          chk(!req_w && req_a == 16'h1005, "R9 read of rx override", {req_w, req_a}, 16'h1005);
          if (txn % 4 == 2)
            chk(cyc - t_wr1 >= RC, "R9 hold time", cyc - t_wr1, RC);
          rsp_wait = 2;
        end
        1: begin
          chk(req_w && req_a == 16'h1005 && req_d == (phy_reg | 16'h0028),
              "R9 set override bits", req_d, phy_reg | 16'h0028);
          phy_reg = req_d;
          t_wr1   = cyc;
        end
        default: begin
          chk(req_w && req_a == 16'h1005 && req_d == (phy_reg & ~16'h0028),
              "R9 clear override bits", req_d, phy_reg & ~16'h0028);
          phy_reg = req_d;
        end
      endcase
      txn++;
    end
    prev_v     = req_v;
    prev_rdy   = p_ready;
    prev_a     = req_a;
    prev_d     = req_d;
    prev_w     = req_w;
    prev_train = train_en;
  end

  always @(negedge clk) begin
    if (cyc > 100000 && !fin) begin
      fin = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic pulse(input bit skip);
    if (skip) start_s = 1'b1; else start = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    start_s = 1'b0;
  endtask

  task automatic wait_idle(input bit skip);
    for (int i = 0; i < 5000; i++) begin
      if (!(skip ? busy_s : busy)) break;
      @(negedge clk);
    end
  endtask

  initial begin
    int t0, n;
    rst_n = 1'b0; start = 1'b0; start_s = 1'b0; gen2 = 1'b0;
    dbg = '0; ctl = '0; stat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !error, "R1 reset idle", {busy, done, error}, 0);
    chk(!train_en && spd_limit == 0 && cur_gen == 0 && !req_v, "R2 reset outputs",
        {train_en, spd_limit, cur_gen, req_v}, 0);

    // Gen2 run: training flag blocks link-up, then speed change completes late.
    gen2 = 1'b1; dbg = 32'h2000_0010; ctl = 32'h0002_0000; stat = 32'h0002_0000;
    t0 = dsc_cnt;
    pulse(1'b0);
    chk(busy && !done, "R1 busy after start", {busy, done}, 2'b10);
    repeat (20) @(negedge clk);
    chk(busy && !done && spd_limit == 4'd1, "R3 training flag holds off link-up",
        {busy, done, spd_limit}, 6'b10_0001);
    dbg = 32'h0000_0010;
    for (int i = 0; i < 200; i++) begin
      if (spd_limit == 4'd2) break;
      @(negedge clk);
    end
    chk(spd_limit == 4'd2, "R4 limit raised to 2", spd_limit, 2);
    pulse(1'b0);
    chk(spd_limit == 4'd2 && train_en && busy, "R1 start while busy ignored",
        {spd_limit, train_en, busy}, 6'b0010_11);
    repeat (30) @(negedge clk);
    chk(busy && !done, "R5 waits on pending speed change", {busy, done}, 2'b10);
    ctl = '0;
    wait_idle(1'b0);
    chk(done && !error, "R8 gen2 success", {done, error}, 2'b10);
    chk(cur_gen == 4'd2, "R8 reported generation", cur_gen, 2);
    chk(dsc_cnt - t0 == 1, "R4 single speed-change pulse", dsc_cnt - t0, 1);

    // Gen1 target.
    gen2 = 1'b0; stat = 32'h0001_0000; ctl = 32'h0002_0000; dbg = 32'h0000_0010;
    t0 = dsc_cnt;
    pulse(1'b0);
    chk(!done && busy, "R1 start clears done", {done, busy}, 2'b01);
    wait_idle(1'b0);
    chk(done && cur_gen == 4'd1 && spd_limit == 4'd1, "R7 gen1 run",
        {done, cur_gen, spd_limit}, 9'b1_0001_0001);
    chk(dsc_cnt == t0, "R7 no speed-change request", dsc_cnt - t0, 0);

    // Link-up on the last permitted poll: success must win over expiry.
    dbg = '0;
    pulse(1'b0);
    repeat (4 * LP) @(negedge clk);
    dbg = 32'h0000_0010;
    wait_idle(1'b0);
    chk(done && !error, "R3 link-up on last poll succeeds", {done, error}, 2'b10);

    // Link-up two cycles too late: timeout and recovery.
    dbg = '0;
    pulse(1'b0);
    repeat (4 * LP + 2) @(negedge clk);
    dbg = 32'h0000_0010;
    chk(error && busy && !done, "R3 timeout after last poll", {error, busy, done}, 3'b110);
    t0 = txn;
    wait_idle(1'b0);
    chk(txn - t0 == 4, "R9 recovery transfer count", txn - t0, 4);
    chk(phy_reg == 16'h1214, "R9 override bits restored", phy_reg, 16'h1214);
    repeat (10) @(negedge clk);
    chk(error && !done && !busy, "R10 error sticky", {error, done, busy}, 3'b100);

    // Speed change never completes.
    gen2 = 1'b1; ctl = 32'h0002_0000; stat = 32'h0002_0000;
    pulse(1'b0);
    chk(!error, "R10 start clears error", error, 0);
    n = 1;
    for (int i = 0; i < 3000; i++) begin
      if (error) break;
      n++;
      @(negedge clk);
    end
    chk(error && n >= SP * PC, "R5 speed-change poll expiry", n, SP * PC);
    chk(spd_limit == 4'd2 && busy, "R10 busy through recovery", {spd_limit, busy}, 5'b0010_1);
    t0 = txn;
    wait_idle(1'b0);
    chk(txn - t0 == 4 && !done, "R9 recovery after speed failure", txn - t0, 4);

    // Variant that ignores the pending bit.
    ctl = 32'h0002_0000; dbg = 32'h0000_0010; stat = 32'h0002_0000;
    pulse(1'b1);
    wait_idle(1'b1);
    chk(done_s && !error_s && cur_gen_s == 4'd2, "R6 skip variant completes",
        {done_s, error_s, cur_gen_s}, 6'b10_0010);
    chk(spd_limit_s == 4'd2, "R6 skip variant raised limit", spd_limit_s, 2);
    chk(!busy, "R1 other instance untouched", busy, 0);

    fin = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule